// File: doc/BRIEF.md
# Flash Array Window Controller with Program-Verify Read Path

This block sits between a word-wide system bus and an on-chip flash array. It holds a relocatable base address that places the array in a window of the 24-bit address space, and a four-bit control register that steers programming, erasure and read-back. Bus reads that fall in the window return one of three things, chosen when the read is accepted: the stored word, the stored word XOR the data captured from the last program write (so a fully programmed location reads as zero), or the captured address.

The array itself is modelled as a bank of synchronous words. Each word is driven to all ones by a whole-array erase and ANDed with the captured data by a program strobe. Software arms the capture by setting the latch bit, writes the target word once, then sets the enable bit to fire a program or an erase. The base address loads from strap inputs at reset and can only be moved while the lock input is low and the stop input is high.

Top module: `flash_rdpath`

## Requirements
- R1: During and after reset the control register is zero, the high base register holds `shd_hi` and the low base register holds `shd_lo`. The reset input is asynchronous and active low, and the block leaves reset two clock edges after it is released.
- R2: A bus access hits when `bus_req` is high and bus address bits 23:16 equal the high base and bits 15:14 equal the low base. `array_hit` follows this combinationally. A read that hits raises `rd_valid` on the next cycle with its data. At every other time `rd_valid` is 0 and `rd_data` is 0.
- R3: A read accepted while verify (control bit 3) and latch (bit 1) are 1 and erase-select (bit 2) is 0 returns the stored word XOR the captured data. The result is zero for a fully programmed location.
- R4: A read accepted while latch is 1 and both erase-select and verify are 0 returns bits 15:0 of the captured address.
- R5: A read accepted while latch is 0, or while latch and erase-select are both 1, returns the stored word at bus address bits 5:0.
- R6: While enable (bit 0) is 1, a control write leaves verify and erase-select unchanged, while latch and enable take the written values.
- R7: A control-register write with `bus_super` low is ignored. A control read with `bus_super` low returns 0.
- R8: A write to a base register (`reg_sel` 0 = high base, data bits 7:0; `reg_sel` 1 = low base, data bits 15:14) takes effect only when `win_lock` is 0 and `win_stop` is 1, and it moves the hit window.
- R9: While latch is 1, the first array write that hits captures bits 15:0 of its address and its data. Later writes are not captured until latch has been cleared and set again.
- R10: A control write that takes enable from 0 to 1 with latch 1 sets every word to 0xFFFF in one cycle if erase-select is 1. If erase-select is 0 and a write has been captured, it ANDs the captured data into the captured word. The new latch and erase-select values decide which action is taken.
- R11: Register reads are combinational on `reg_sel`: 0 gives the high base in bits 7:0, 1 gives the low base in bits 15:14, 2 gives the control bits in 3:0, and 3 gives 0. All other bits read as 0, and `reg_rdata` is 0 while `reg_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Array-space access strobe |
| bus_we | input | 1 | Array access is a write |
| bus_super | input | 1 | Access made in supervisor mode |
| bus_addr | input | 24 | Array access address |
| bus_wdata | input | 16 | Array write data |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Register access is a write |
| reg_sel | input | 2 | Register select (0 high base, 1 low base, 2 control) |
| reg_wdata | input | 16 | Register write data |
| win_lock | input | 1 | Base relocation lock |
| win_stop | input | 1 | Stop state; base may move only when 1 |
| shd_hi | input | 8 | Reset value of base bits 23:16 |
| shd_lo | input | 2 | Reset value of base bits 15:14 |
| array_hit | output | 1 | Current access falls in the array window |
| rd_valid | output | 1 | Array read data valid |
| rd_data | output | 16 | Array read data |
| reg_rdata | output | 16 | Register read data |

## Verification
The bound checker watches, on every cycle, the rules that hold regardless of data values: the frozen verify and erase-select bits while enable is set, the user-mode and lock guards on register writes, the quiet read bus outside valid cycles, and the stability of captured values while latch stays set. What each read returns under verify, address readback and plain modes, whether erase reaches every word, whether programming lands on the captured word, and whether relocation moves the window can only be shown by the bench's scenarios. There, a behavioural model follows the same bus traffic and is compared with the outputs on every cycle.

// File: rtl/fl_pkg.sv
package fl_pkg;

  // Register select codes seen on reg_sel
  typedef enum logic [1:0] {
    SEL_BHI  = 2'd0,
    SEL_BLO  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Control bits, MSB first: verify, erase-select, latch, enable
  typedef struct packed {
    logic vfy;
    logic ers;
    logic lat;
    logic enp;
  } ctl_t;

  localparam int CTL_VFY = 3;
  localparam int CTL_ERS = 2;
  localparam int CTL_LAT = 1;
  localparam int CTL_ENP = 0;
  localparam int CTL_W   = 4;

  // What a read returns once accepted
  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_XOR   = 2'd1,
    RD_ADDR  = 2'd2
  } rd_mode_e;

endpackage

// File: rtl/fl_regs.sv
module fl_regs
  import fl_pkg::*;
#(
  parameter int DW   = 16,
  parameter int HI_W = 8,
  parameter int LO_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_req,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            super_i,
  input  logic            lock_i,
  input  logic            stop_i,
  input  logic [HI_W-1:0] shd_hi,
  input  logic [LO_W-1:0] shd_lo,
  output logic [HI_W-1:0] base_hi,
  output logic [LO_W-1:0] base_lo,
  output ctl_t            ctl,
  output logic            go,
  output logic            go_lat,
  output logic            go_ers,
  output logic [DW-1:0]   reg_rdata
);

  localparam int PAD_HI  = DW - HI_W;
  localparam int PAD_LO  = DW - LO_W;
  localparam int PAD_CTL = DW - CTL_W;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;
  ctl_t            ctl_q, ctl_d;
  logic            base_wr, ctl_wr;
  logic            wdata_unused;

  assign wdata_unused = ^reg_wdata[DW-LO_W-1:HI_W];

  // next state
  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    ctl_d   = ctl_q;
    base_wr = reg_req && reg_we && !lock_i && stop_i;
    ctl_wr  = reg_req && reg_we && super_i && (reg_sel == SEL_CTL);
    if (base_wr && (reg_sel == SEL_BHI)) hi_d = reg_wdata[HI_W-1:0];
    if (base_wr && (reg_sel == SEL_BLO)) lo_d = reg_wdata[DW-1 -: LO_W];
    if (ctl_wr) begin
      ctl_d.lat = reg_wdata[CTL_LAT];
      ctl_d.enp = reg_wdata[CTL_ENP];
      if (!ctl_q.enp) begin
        ctl_d.vfy = reg_wdata[CTL_VFY];
        ctl_d.ers = reg_wdata[CTL_ERS];
      end
    end
  end

  // strobe for the array: enable rising through a control write
  always_comb begin
    go     = ctl_wr && ctl_d.enp && !ctl_q.enp;
    go_lat = ctl_d.lat;
    go_ers = ctl_d.ers;
  end

  // registers; base loads straps while reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= shd_hi;
      lo_q  <= shd_lo;
      ctl_q <= '0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      ctl_q <= ctl_d;
    end
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_req) begin
      unique case (reg_sel)
        SEL_BHI: reg_rdata = {{PAD_HI{1'b0}}, hi_q};
        SEL_BLO: reg_rdata = {lo_q, {PAD_LO{1'b0}}};
        SEL_CTL: reg_rdata = super_i ? {{PAD_CTL{1'b0}}, ctl_q} : '0;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign base_hi = hi_q;
  assign base_lo = lo_q;
  assign ctl     = ctl_q;

endmodule

// File: rtl/fl_latch.sv
module fl_latch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_en,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cap_v,
  output logic [DW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);

  logic          v_q, v_d;
  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] d_q, d_d;
  logic          take;

  always_comb begin
    take = lat_en && wr_hit && !v_q;
    v_d  = v_q;
    a_d  = a_q;
    d_d  = d_q;
    if (!lat_en) begin
      v_d = 1'b0;
    end else if (take) begin
      v_d = 1'b1;
      a_d = wr_addr;
      d_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_d;
    end
  end

  // payload registers with an explicit capture enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      d_q <= '0;
    end else if (take) begin
      a_q <= a_d;
      d_q <= d_d;
    end
  end

  assign cap_v    = v_q;
  assign cap_addr = a_q;
  assign cap_data = d_q;

endmodule

// File: rtl/fl_array.sv
module fl_array #(
  parameter int DW    = 16,
  parameter int WORDS = 64,
  parameter int IDXW  = 6
) (
  input  logic            clk,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  input  logic            go,
  input  logic            go_lat,
  input  logic            go_ers,
  input  logic            cap_v,
  input  logic [IDXW-1:0] cap_idx,
  input  logic [DW-1:0]   cap_data,
  output logic [DW-1:0]   rd_word
);

  logic [DW-1:0] words [WORDS];
  logic [DW-1:0] rd_q;
  logic          erase_all, prog_one;

  always_comb begin
    erase_all = go && go_lat && go_ers;
    prog_one  = go && go_lat && !go_ers && cap_v;
  end

  // one storage word per slot; erase reaches all of them at once
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] cell_q;
    logic          cell_en;
    logic [DW-1:0] cell_d;

    always_comb begin
      cell_en = erase_all || (prog_one && (cap_idx == IDXW'(w)));
      cell_d  = erase_all ? {DW{1'b1}} : (cell_q & cap_data);
    end

    always_ff @(posedge clk) begin
      if (cell_en) cell_q <= cell_d;
    end

    assign words[w] = cell_q;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= words[rd_idx];
  end

  assign rd_word = rd_q;

endmodule

// File: rtl/fl_rdmux.sv
module fl_rdmux
  import fl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  ctl_t          ctl,
  input  logic [DW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic [DW-1:0] rd_word,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic          vld_q;
  rd_mode_e      mode_q, mode_d;
  logic [DW-1:0] opnd_q, opnd_d;

  // mode and operand chosen when the read is accepted
  always_comb begin
    mode_d = RD_ARRAY;
    opnd_d = '0;
    if (ctl.lat && !ctl.ers) begin
      if (ctl.vfy) begin
        mode_d = RD_XOR;
        opnd_d = cap_data;
      end else begin
        mode_d = RD_ADDR;
        opnd_d = cap_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RD_ARRAY;
      opnd_q <= '0;
    end else if (rd_req) begin
      mode_q <= mode_d;
      opnd_q <= opnd_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (vld_q) begin
      unique case (mode_q)
        RD_XOR:  rd_data = rd_word ^ opnd_q;
        RD_ADDR: rd_data = opnd_q;
        default: rd_data = rd_word;
      endcase
    end
  end

  assign rd_valid = vld_q;

endmodule

// File: rtl/flash_rdpath.sv
module flash_rdpath
  import fl_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int WIN_LSB = 14,
  parameter int WORDS   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic             bus_super,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             win_lock,
  input  logic             win_stop,
  input  logic [AW-17:0]   shd_hi,
  input  logic [15-WIN_LSB:0] shd_lo,
  output logic             array_hit,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    reg_rdata
);

  localparam int HI_W = AW - 16;
  localparam int LO_W = 16 - WIN_LSB;
  localparam int IDXW = $clog2(WORDS);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic [HI_W-1:0] base_hi_q;
  logic [LO_W-1:0] base_lo_q;
  ctl_t            ctl_q;
  logic            go, go_lat, go_ers;
  logic            cap_v;
  logic [DW-1:0]   cap_addr, cap_data;
  logic [DW-1:0]   rd_word;
  logic            hit, rd_req, wr_hit;

  always_comb begin
    hit    = bus_req && (bus_addr[AW-1:16] == base_hi_q)
                     && (bus_addr[15:WIN_LSB] == base_lo_q);
    rd_req = hit && !bus_we;
    wr_hit = hit && bus_we;
  end

  assign array_hit = hit;

  fl_regs #(.DW(DW), .HI_W(HI_W), .LO_W(LO_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .super_i   (bus_super),
    .lock_i    (win_lock),
    .stop_i    (win_stop),
    .shd_hi    (shd_hi),
    .shd_lo    (shd_lo),
    .base_hi   (base_hi_q),
    .base_lo   (base_lo_q),
    .ctl       (ctl_q),
    .go        (go),
    .go_lat    (go_lat),
    .go_ers    (go_ers),
    .reg_rdata (reg_rdata)
  );

  fl_latch #(.DW(DW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_s),
    .lat_en   (ctl_q.lat),
    .wr_hit   (wr_hit),
    .wr_addr  (bus_addr[DW-1:0]),
    .wr_data  (bus_wdata),
    .cap_v    (cap_v),
    .cap_addr (cap_addr),
    .cap_data (cap_data)
  );

  fl_array #(.DW(DW), .WORDS(WORDS), .IDXW(IDXW)) u_array (
    .clk      (clk),
    .rd_en    (rd_req),
    .rd_idx   (bus_addr[IDXW-1:0]),
    .go       (go),
    .go_lat   (go_lat),
    .go_ers   (go_ers),
    .cap_v    (cap_v),
    .cap_idx  (cap_addr[IDXW-1:0]),
    .cap_data (cap_data),
    .rd_word  (rd_word)
  );

  fl_rdmux #(.DW(DW)) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_s),
    .rd_req   (rd_req),
    .ctl      (ctl_q),
    .cap_addr (cap_addr),
    .cap_data (cap_data),
    .rd_word  (rd_word),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter int DW   = 16,
  parameter int HI_W = 8,
  parameter int LO_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_req,
  input logic            bus_we,
  input logic            bus_super,
  input logic            reg_req,
  input logic            reg_we,
  input logic [1:0]      reg_sel,
  input logic [DW-1:0]   reg_rdata,
  input logic            win_lock,
  input logic            win_stop,
  input logic            array_hit,
  input logic            rd_valid,
  input logic [DW-1:0]   rd_data,
  input logic [3:0]      ctl,
  input logic [HI_W-1:0] base_hi,
  input logic [LO_W-1:0] base_lo,
  input logic            cap_v,
  input logic [DW-1:0]   cap_addr,
  input logic [DW-1:0]   cap_data
);

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0)) else $error("read bus not quiet"); // R2

  AST_MISS_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we && array_hit) |=> !rd_valid) else $error("valid without hit"); // R2

  AST_FROZEN_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[0] |=> ($stable(ctl[3]) && $stable(ctl[2]))) else $error("mode bits moved"); // R6

  AST_USER_NO_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && !bus_super && reg_sel == 2'd2) |=> $stable(ctl)) else $error("user write landed"); // R7

  AST_USER_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !bus_super && reg_sel == 2'd2) |-> (reg_rdata == '0)) else $error("user read leaked"); // R7

  AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && (win_lock || !win_stop)) |=> ($stable(base_hi) && $stable(base_lo))) else $error("base moved while locked"); // R8

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v && ctl[1]) |=> ($stable(cap_addr) && $stable(cap_data))) else $error("capture overwritten"); // R9

  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_sel == 2'd2) |-> (reg_rdata[DW-1:4] == '0)) else $error("control upper bits set"); // R11

endmodule

bind flash_rdpath fl_checker #(.DW(DW), .HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_super (bus_super),
  .reg_req   (reg_req),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .win_lock  (win_lock),
  .win_stop  (win_stop),
  .array_hit (array_hit),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .ctl       (ctl_q),
  .base_hi   (base_hi_q),
  .base_lo   (base_lo_q),
  .cap_v     (cap_v),
  .cap_addr  (cap_addr),
  .cap_data  (cap_data)
);

// File: tb/flash_rdpath_test.sv
module flash_rdpath_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_super = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        win_lock = 1'b0, win_stop = 1'b1;
  logic [7:0]  shd_hi = 8'h12;
  logic [1:0]  shd_lo = 2'b01;
  logic        array_hit, rd_valid;
  logic [15:0] rd_data, reg_rdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_rdpath uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_super(bus_super), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .win_lock(win_lock), .win_stop(win_stop), .shd_hi(shd_hi), .shd_lo(shd_lo),
    .array_hit(array_hit), .rd_valid(rd_valid), .rd_data(rd_data), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         rs1, rs2;
  bit  [7:0]  m_hi;
  bit  [1:0]  m_lo;
  bit         m_vfy, m_ers, m_lat, m_enp;
  bit         m_capv;
  bit  [15:0] m_capa, m_capd;
  bit  [15:0] m_mem [64];
  bit         m_vld;
  bit  [15:0] m_exp;
  string      m_tag = "R2";

  task automatic m_reset();
    m_hi = shd_hi; m_lo = shd_lo;
    {m_vfy, m_ers, m_lat, m_enp} = 4'b0;
    m_capv = 0; m_capa = 0; m_capd = 0;
    m_vld = 0; m_exp = 0; m_tag = "R2";
  endtask

  function automatic bit m_hit();
    return bus_req && (bus_addr[23:16] == m_hi) && (bus_addr[15:14] == m_lo);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; m_reset();
    end else begin
      if (!rs2) begin
        m_reset();
      end else begin
        bit h, nv, go, nvfy, ners, nlat, nenp, ncapv;
        bit [7:0]  nhi;
        bit [1:0]  nlo;
        bit [15:0] ncapa, ncapd, ne, w;
        string     ntag;
        h = m_hit();
        nv = h && !bus_we;
        ne = 0; ntag = "R2";
        if (nv) begin
          w = m_mem[bus_addr[5:0]];
          if (m_lat && !m_ers) begin
            ne = m_vfy ? (w ^ m_capd) : m_capa;
            ntag = m_vfy ? "R3" : "R4";
          end else begin
            ne = w; ntag = "R5";
          end
        end
        ncapv = m_capv; ncapa = m_capa; ncapd = m_capd;
        if (!m_lat) ncapv = 0;
        else if (h && bus_we && !m_capv) begin
          ncapv = 1; ncapa = bus_addr[15:0]; ncapd = bus_wdata;
        end
        nhi = m_hi; nlo = m_lo;
        if (reg_req && reg_we && !win_lock && win_stop) begin
          if (reg_sel == 2'd0) nhi = reg_wdata[7:0];
          if (reg_sel == 2'd1) nlo = reg_wdata[15:14];
        end
        nvfy = m_vfy; ners = m_ers; nlat = m_lat; nenp = m_enp; go = 0;
        if (reg_req && reg_we && bus_super && reg_sel == 2'd2) begin
          nlat = reg_wdata[1]; nenp = reg_wdata[0];
          if (!m_enp) begin nvfy = reg_wdata[3]; ners = reg_wdata[2]; end
          go = nenp && !m_enp;
        end
        if (go && nlat) begin
          if (ners) for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
          else if (m_capv) m_mem[m_capa[5:0]] = m_mem[m_capa[5:0]] & m_capd;
        end
        m_hi = nhi; m_lo = nlo;
        {m_vfy, m_ers, m_lat, m_enp} = {nvfy, ners, nlat, nenp};
        m_capv = ncapv; m_capa = ncapa; m_capd = ncapd;
        m_vld = nv; m_exp = ne; m_tag = ntag;
      end
      rs2 = rs1; rs1 = 1;
    end
  end

  function automatic bit [15:0] m_reg();
    if (!reg_req) return 16'h0;
    case (reg_sel)
      2'd0: return {8'h00, m_hi};
      2'd1: return {m_lo, 14'h0};
      2'd2: return bus_super ? {12'h000, m_vfy, m_ers, m_lat, m_enp} : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rs2 && !done) begin
      chk(m_tag, "rd_data", rd_data, m_exp);
      chk("R2", "rd_valid", rd_valid, m_vld);
      chk("R2", "array_hit", array_hit, m_hit());
      chk("R11", "reg_rdata", reg_rdata, m_reg());
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic regw(input logic [1:0] s, input logic [15:0] d, input bit sup);
    @(posedge clk); #2;
    reg_req = 1; reg_we = 1; reg_sel = s; reg_wdata = d; bus_super = sup;
    @(posedge clk); #2;
    reg_req = 0; reg_we = 0; bus_super = 1;
  endtask

  task automatic regr(input logic [1:0] s, input bit sup, output logic [15:0] v);
    @(posedge clk); #2;
    reg_req = 1; reg_we = 0; reg_sel = s; bus_super = sup;
    #1 v = reg_rdata;
    @(posedge clk); #2;
    reg_req = 0; bus_super = 1;
  endtask

  task automatic arw(input logic [23:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic arr(input logic [23:0] a, output logic [15:0] v, output logic vl, output logic h);
    @(posedge clk); #2;
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 h = array_hit;
    @(posedge clk); #2;
    bus_req = 0;
    v = rd_data; vl = rd_valid;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        vl, h;
    #23 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    regr(2'd0, 1, v); chk("R1", "base hi reset", v, 16'h0012);
    regr(2'd1, 1, v); chk("R1", "base lo reset", v, 16'h4000);
    regr(2'd2, 1, v); chk("R1", "ctl reset", v, 16'h0000);
    regr(2'd3, 1, v); chk("R11", "unused select", v, 16'h0000);

    // R10 whole-array erase
    regw(2'd2, 16'h0006, 1);
    regw(2'd2, 16'h0007, 1);
    regw(2'd2, 16'h0006, 1);
    regw(2'd2, 16'h0000, 1);
    arr(24'h124005, v, vl, h); chk("R10", "erased word", v, 16'hFFFF);
    chk("R5", "plain read valid", vl, 1'b1);

    // R9 capture first write only, R4 address readback
    regw(2'd2, 16'h0002, 1);
    arw(24'h124005, 16'h1234);
    arw(24'h124009, 16'hAAAA);
    arr(24'h124009, v, vl, h); chk("R4", "latched address", v, 16'h4005);
    regw(2'd2, 16'h0003, 1);
    regw(2'd2, 16'h0002, 1);

    // R3 program verify
    regw(2'd2, 16'h000A, 1);
    arr(24'h124005, v, vl, h); chk("R3", "programmed word xor", v, 16'h0000);
    arr(24'h124009, v, vl, h); chk("R9", "second write not captured", v, 16'hEDCB);

    // R6 mode bits frozen while enable set
    regw(2'd2, 16'h000B, 1);
    regw(2'd2, 16'h0007, 1);
    regr(2'd2, 1, v); chk("R6", "vfy/ers held", v, 16'h000B);
    regw(2'd2, 16'h0000, 1);
    regr(2'd2, 1, v); chk("R6", "vfy held on clear", v, 16'h0008);
    regw(2'd2, 16'h0000, 1);

    // R7 user-mode guard
    regw(2'd2, 16'h0002, 1);
    regw(2'd2, 16'h0000, 0);
    regr(2'd2, 1, v); chk("R7", "user write ignored", v, 16'h0002);
    regr(2'd2, 0, v); chk("R7", "user read zero", v, 16'h0000);
    regw(2'd2, 16'h0000, 1);

    // R5 plain reads, latch off and latch with erase-select
    arr(24'h124005, v, vl, h); chk("R5", "latch off read", v, 16'h1234);
    regw(2'd2, 16'h0006, 1);
    arr(24'h124005, v, vl, h); chk("R5", "latch+erase read", v, 16'h1234);
    regw(2'd2, 16'h0000, 1);

    // R2 miss
    arr(24'h128005, v, vl, h);
    chk("R2", "miss hit", h, 1'b0);
    chk("R2", "miss valid", vl, 1'b0);
    chk("R2", "miss data", v, 16'h0000);

    // R8 relocation guard and move
    win_lock = 1;
    regw(2'd0, 16'h0034, 1);
    regr(2'd0, 1, v); chk("R8", "locked write", v, 16'h0012);
    win_lock = 0; win_stop = 0;
    regw(2'd0, 16'h0034, 1);
    regr(2'd0, 1, v); chk("R8", "not stopped write", v, 16'h0012);
    win_stop = 1;
    regw(2'd0, 16'h0034, 1);
    regw(2'd1, 16'hC000, 1);
    regr(2'd0, 1, v); chk("R8", "moved hi", v, 16'h0034);
    regr(2'd1, 1, v); chk("R8", "moved lo", v, 16'hC000);
    arr(24'h34C005, v, vl, h); chk("R8", "new window read", v, 16'h1234);
    arr(24'h124005, v, vl, h); chk("R8", "old window miss", vl, 1'b0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule